// File: doc/BRIEF.md
# Shift-Based Batch Normalizer

This block normalizes one mini-batch of signed fixed-point activations using shifts in place of multipliers and a divider. Samples arrive one per cycle on a valid/last stream and are written into an internal buffer. Once the batch is complete the block makes three passes over the buffer. The first pass forms the mean. The second forms an approximate variance. The third streams out each centered sample, normalized and scaled by a learned factor, then offset by a learned bias.

Every scaling step uses a power-of-two approximation AP2(v) = sign(v) * 2^e. The exponent e is the index of the most significant set bit of |v|, plus one when the bit just below that one is set. A zero magnitude contributes zero. The batch size M = 2^LOG2_M, so dividing by M is an arithmetic right shift. The scale `gamma` is a signed fixed-point value with FRAC_W fractional bits (value 2^FRAC_W means 1.0). `beta` and the results are plain signed integers of DATA_W bits. The caller holds `gamma` and `beta` steady while a batch is being processed.

Top module: `sbn_batchnorm`

## Requirements
- R1: After reset `busy` is low, `in_ready` is high and `out_valid` is low.
- R2: While `in_ready` is high, every cycle with `in_valid` high stores one sample. The M-th stored sample completes the batch, whether or not `in_last` is set with it, and `busy` is high from the next cycle on.
- R3: If `in_last` is set on a sample before the M-th, the partial batch is discarded. Collection restarts at slot zero and no result is produced.
- R4: While `busy` is high, `in_ready` is low and `in_valid` samples are ignored. They do not alter the results of the batch in progress.
- R5: mean = floor(sum of the M samples / M), by arithmetic shift. Each centered value is c = x - mean.
- R6: The AP2 exponent is the leading-one index of the magnitude, plus 1 when the next lower bit is 1. A zero magnitude yields a zero product.
- R7: var = floor(sum over the batch of (|c| << e(|c|)) / M). With E = e(var + EPS), the shift is s = ceil(E/2), and the normalized value is n = (c << FRAC_W) >>> s.
- R8: t = (n << e(|gamma|)) >>> FRAC_W, negated when gamma is negative and forced to 0 when gamma is 0. Each result is t + beta.
- R9: A result outside the signed DATA_W range saturates to the nearest bound.
- R10: The M results leave in sample order on consecutive cycles, and `out_last` is set on the final one only. The first result is presented 2M+1 cycles after the cycle in which the last sample was stored.
- R11: `busy` falls in the same cycle that the final result is presented, so a sample offered in that cycle is stored as the first of the next batch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | DATA_W | Signed sample |
| in_last | input | 1 | Marks the final sample of a batch |
| in_ready | output | 1 | Block can store a sample |
| gamma | input | DATA_W | Signed scale, FRAC_W fractional bits |
| beta | input | DATA_W | Signed bias added to each result |
| out_valid | output | 1 | Result present |
| out_data | output | DATA_W | Signed, saturated result |
| out_last | output | 1 | Final result of the batch |
| busy | output | 1 | Batch being processed |

## Verification
The delicate overlap is the final result of one batch being presented in the same cycle that the first sample of the next batch is stored. The bench provokes it by driving a new batch from the exact sampling point at which `out_last` is seen. It then checks that `busy` is already low there and that every value of the second batch matches the model. A second overlap is stimulus offered during the processing passes. Here the bench drives garbage with `in_valid` high throughout the sum and variance passes, and judges by `in_ready` staying low and by the results of that batch being unchanged.

// File: rtl/sbn_pkg.sv
`timescale 1ns/1ps
package sbn_pkg;

    // Processing phase; PH_FILL must be the all-zero encoding (reset value).
    typedef enum logic [1:0] {
        PH_FILL = 2'd0,
        PH_SUM  = 2'd1,
        PH_VAR  = 2'd2,
        PH_EMIT = 2'd3
    } phase_e;

endpackage

// File: rtl/sbn_ap2.sv
`timescale 1ns/1ps
// Rounded power-of-two exponent of an unsigned magnitude.
module sbn_ap2 #(
    parameter int W  = 12,
    parameter int EW = $clog2(W + 1)
) (
    input  logic [W-1:0]  mag_i,
    output logic [EW-1:0] exp_o,
    output logic          zero_o
);

    logic [W-1:0]  below;
    logic [EW-1:0] lead;
    logic          rnd;

    // below[i] is the bit one position under mag_i[i]
    assign below = {mag_i[W-2:0], 1'b0};

    always_comb begin
        lead = '0;
        rnd  = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (mag_i[i]) begin
                lead = EW'(i);
                rnd  = below[i];
            end
        end
    end

    assign exp_o  = lead + EW'(rnd);
    assign zero_o = ~|mag_i;

endmodule

// File: rtl/sbn_sample_buf.sv
`timescale 1ns/1ps
// Register-based sample store, one write and one asynchronous read port.
module sbn_sample_buf #(
    parameter int DATA_W = 12,
    parameter int AW     = 3,
    parameter int DEPTH  = 1 << AW
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH*DATA_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(g))) begin
                slot_q <= wr_data;
            end
        end
        assign flat[g*DATA_W +: DATA_W] = slot_q;
    end

    assign rd_data = flat[int'(rd_addr)*DATA_W +: DATA_W];

endmodule

// File: rtl/sbn_batchnorm.sv
`timescale 1ns/1ps
module sbn_batchnorm
    import sbn_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int LOG2_M = 3,
    parameter int FRAC_W = 6,
    parameter int EPS    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     in_last,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] gamma,
    input  logic signed [DATA_W-1:0] beta,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data,
    output logic                     out_last,
    output logic                     busy
);

    localparam int M      = 1 << LOG2_M;
    localparam int IDX_W  = LOG2_M;
    localparam int C_W    = DATA_W + 1;
    localparam int SUM_W  = DATA_W + LOG2_M;
    localparam int CEW    = $clog2(C_W + 1);
    localparam int TERM_W = 2 * C_W;
    localparam int ACC_W  = TERM_W + LOG2_M;
    localparam int VE_W   = TERM_W + 1;
    localparam int VEW    = $clog2(VE_W + 1);
    localparam int GW     = $clog2(DATA_W + 1);
    localparam int W_W    = C_W + FRAC_W + DATA_W + 3;

    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(M - 1);
    localparam logic [C_W-1:0]    C_ONE    = C_W'(1);
    localparam logic [DATA_W-1:0] D_ONE    = DATA_W'(1);

    typedef struct packed {
        phase_e                    phase;
        logic [IDX_W-1:0]          idx;
        logic signed [SUM_W-1:0]   sum;
        logic signed [DATA_W-1:0]  mean;
        logic [ACC_W-1:0]          acc;
        logic [VEW-1:0]            shift;
        logic                      ovalid;
        logic                      olast;
        logic signed [DATA_W-1:0]  odata;
    } st_t;

    st_t st_q, st_d;

    // buffer signals
    logic                     wr_en;
    logic signed [DATA_W-1:0] rd_data;

    // sum pass
    logic signed [SUM_W-1:0]  sum_nx;
    logic signed [DATA_W-1:0] mean_nx;

    // centering and variance pass
    logic signed [C_W-1:0]    cval;
    logic [C_W-1:0]           cmag;
    logic [CEW-1:0]           c_exp;
    logic                     c_zero;
    logic [TERM_W-1:0]        term;
    logic [ACC_W-1:0]         acc_nx;
    logic [VE_W-1:0]          ve;
    logic [VEW-1:0]           ve_exp;
    logic                     ve_zero;
    logic [VEW-1:0]           shift_nx;

    // output pass
    logic [DATA_W-1:0]        gmag;
    logic [GW-1:0]            g_exp;
    logic                     g_zero;
    logic signed [W_W-1:0]    cw;
    logic signed [W_W-1:0]    nw;
    logic signed [W_W-1:0]    tw;
    logic signed [W_W-1:0]    sw;
    logic signed [W_W-1:0]    yw;
    logic signed [DATA_W-1:0] ysat;
    logic                     y_ovf;

    sbn_sample_buf #(
        .DATA_W (DATA_W),
        .AW     (IDX_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (st_q.idx),
        .wr_data (in_data),
        .rd_addr (st_q.idx),
        .rd_data (rd_data)
    );

    // ---------------- sum pass ----------------
    assign sum_nx  = st_q.sum + {{(SUM_W-DATA_W){rd_data[DATA_W-1]}}, rd_data};
    assign mean_nx = sum_nx[LOG2_M +: DATA_W];

    // ---------------- centering / variance ----------------
    assign cval = {{(C_W-DATA_W){rd_data[DATA_W-1]}}, rd_data}
                - {{(C_W-DATA_W){st_q.mean[DATA_W-1]}}, st_q.mean};
    assign cmag = cval[C_W-1] ? (~cval + C_ONE) : cval;

    sbn_ap2 #(.W(C_W), .EW(CEW)) u_ap2_term (
        .mag_i  (cmag),
        .exp_o  (c_exp),
        .zero_o (c_zero)
    );

    assign term   = c_zero ? '0 : ({{(TERM_W-C_W){1'b0}}, cmag} << c_exp);
    assign acc_nx = st_q.acc + {{(ACC_W-TERM_W){1'b0}}, term};
    assign ve     = {1'b0, acc_nx[ACC_W-1:LOG2_M]} + VE_W'(EPS);

    sbn_ap2 #(.W(VE_W), .EW(VEW)) u_ap2_var (
        .mag_i  (ve),
        .exp_o  (ve_exp),
        .zero_o (ve_zero)
    );

    // ceil(E/2); a zero sum (EPS == 0) leaves the values unshifted
    assign shift_nx = ve_zero ? '0 : VEW'((ve_exp + VEW'(1)) >> 1);

    // ---------------- output pass ----------------
    assign gmag = gamma[DATA_W-1] ? (~gamma + D_ONE) : gamma;

    sbn_ap2 #(.W(DATA_W), .EW(GW)) u_ap2_gamma (
        .mag_i  (gmag),
        .exp_o  (g_exp),
        .zero_o (g_zero)
    );

    assign cw = {{(W_W-C_W){cval[C_W-1]}}, cval};
    assign nw = (cw <<< FRAC_W) >>> st_q.shift;
    assign tw = (nw <<< g_exp) >>> FRAC_W;
    assign sw = g_zero ? '0 : (gamma[DATA_W-1] ? -tw : tw);
    assign yw = sw + {{(W_W-DATA_W){beta[DATA_W-1]}}, beta};

    // in range only when all bits from the result sign upward agree
    assign y_ovf = !((&yw[W_W-1:DATA_W-1]) || !(|yw[W_W-1:DATA_W-1]));
    assign ysat  = y_ovf ? (yw[W_W-1] ? {1'b1, {(DATA_W-1){1'b0}}}
                                      : {1'b0, {(DATA_W-1){1'b1}}})
                         : yw[DATA_W-1:0];

    // ---------------- next-state ----------------
    always_comb begin
        st_d        = st_q;
        st_d.ovalid = 1'b0;
        st_d.olast  = 1'b0;
        wr_en       = 1'b0;
        unique case (st_q.phase)
            PH_FILL: begin
                if (in_valid) begin
                    wr_en = 1'b1;
                    if (st_q.idx == IDX_LAST) begin
                        st_d.phase = PH_SUM;
                        st_d.idx   = '0;
                        st_d.sum   = '0;
                    end else if (in_last) begin
                        st_d.idx = '0;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
            end
            PH_SUM: begin
                st_d.sum = sum_nx;
                st_d.idx = st_q.idx + IDX_W'(1);
                if (st_q.idx == IDX_LAST) begin
                    st_d.phase = PH_VAR;
                    st_d.mean  = mean_nx;
                    st_d.acc   = '0;
                end
            end
            PH_VAR: begin
                st_d.acc = acc_nx;
                st_d.idx = st_q.idx + IDX_W'(1);
                if (st_q.idx == IDX_LAST) begin
                    st_d.phase = PH_EMIT;
                    st_d.shift = shift_nx;
                end
            end
            PH_EMIT: begin
                st_d.ovalid = 1'b1;
                st_d.odata  = ysat;
                st_d.olast  = (st_q.idx == IDX_LAST);
                st_d.idx    = st_q.idx + IDX_W'(1);
                if (st_q.idx == IDX_LAST) begin
                    st_d.phase = PH_FILL;
                end
            end
            default: st_d.phase = PH_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = (st_q.phase == PH_FILL);
    assign busy      = (st_q.phase != PH_FILL);
    assign out_valid = st_q.ovalid;
    assign out_data  = st_q.odata;
    assign out_last  = st_q.olast;

endmodule

// File: rtl/sbn_batchnorm_chk.sv
`timescale 1ns/1ps
module sbn_batchnorm_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic busy,
    input logic out_valid,
    input logic out_last
);

    // R2: processing starts only after a sample was offered
    assert_start_on_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid));

    // R10: results of a batch are contiguous
    assert_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R10: the last flag only accompanies a result
    assert_last_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R10: the first result follows a processing interval
    assert_emit_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(busy));

    // R11: busy released together with the final result
    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> !busy);

    // R11: busy held while earlier results are emitted
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> busy);

endmodule

bind sbn_batchnorm sbn_batchnorm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/sbn_batchnorm_bench.sv
`timescale 1ns/1ps
module sbn_batchnorm_bench;

    localparam int DW  = 12;
    localparam int LM  = 3;
    localparam int M   = 1 << LM;
    localparam int FW  = 6;
    localparam int EPS = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 in_last = 1'b0;
    logic                 in_ready;
    logic signed [DW-1:0] gamma = '0;
    logic signed [DW-1:0] beta = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_data;
    logic                 out_last;
    logic                 busy;

    sbn_batchnorm #(.DATA_W(DW), .LOG2_M(LM), .FRAC_W(FW), .EPS(EPS)) u_sbn_batchnorm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .gamma(gamma), .beta(beta),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .busy(busy)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    longint stim [M];
    longint expv [M];
    longint g_cur = 0;
    longint b_cur = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // rounded leading-one exponent, a > 0 (R6)
    function automatic int ap2e(input longint a);
        int p = 0;
        for (int i = 0; i < 62; i++) if (((a >> i) & 1) != 0) p = i;
        if (p > 0 && (((a >> (p - 1)) & 1) != 0)) return p + 1;
        return p;
    endfunction

    task automatic model();
        longint sum = 0, mean, acc = 0, c, a, v, n, t, y;
        int s;
        for (int i = 0; i < M; i++) sum += stim[i];
        mean = sum >>> LM;                                   // R5
        for (int i = 0; i < M; i++) begin
            c = stim[i] - mean;
            a = (c < 0) ? -c : c;
            if (a != 0) acc += a << ap2e(a);                 // R6/R7
        end
        v = (acc >> LM) + EPS;
        s = (ap2e(v) + 1) / 2;                                // R7
        for (int i = 0; i < M; i++) begin
            c = stim[i] - mean;
            n = (c <<< FW) >>> s;
            if (g_cur == 0) t = 0;                            // R8
            else begin
                t = (n <<< ap2e((g_cur < 0) ? -g_cur : g_cur)) >>> FW;
                if (g_cur < 0) t = -t;
            end
            y = t + b_cur;
            if (y > 2047) y = 2047;                           // R9
            if (y < -2048) y = -2048;
            expv[i] = y;
        end
    endtask

    task automatic set_gb(input longint g, input longint b);
        g_cur = g; b_cur = b;
        gamma = DW'(g); beta = DW'(b);
    endtask

    // called at a negedge, returns at the negedge after the final acceptance
    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = DW'(stim[i]);
            in_last  = (i == n - 1);
            if (i == 0) chk("R2 ready while collecting", in_ready, 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic collect(input bit junk, input string tag);
        int k = 0;
        bit rdy_seen = 1'b0;
        chk("R2 busy after final sample", busy, 1);
        while (!out_valid && k < 10 * M) begin
            if (junk) begin
                in_valid = 1'b1;
                in_data  = 12'sh5a5 + DW'(k);
                in_last  = k[0];
                if (in_ready) rdy_seen = 1'b1;
            end
            @(negedge clk);
            k++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (junk) chk("R4 ready held low while busy", rdy_seen, 0);
        chk("R10 first result latency", k, 2 * M + 1);
        for (int i = 0; i < M; i++) begin
            chk(tag, out_data, expv[i]);
            chk("R10 last flag position", out_last, (i == M - 1));
            if (i < M - 1) begin
                @(negedge clk);
                chk("R10 results on consecutive cycles", out_valid, 1);
            end
        end
        chk("R11 busy low with final result", busy, 0);
        chk("R11 ready with final result", in_ready, 1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R1 busy after reset", busy, 0);
        chk("R1 ready after reset", in_ready, 1);
        chk("R1 out_valid after reset", out_valid, 0);
    endtask

    task automatic test_basic();
        stim = '{100, -50, 300, 7, -200, 0, 55, -12};
        set_gb(64, 0);
        model();
        send(M);
        collect(1'b0, "R5/R7 unit gamma");
        idle(2);
        chk("R10 no result after batch", out_valid, 0);
    endtask

    task automatic test_flat();
        // every centered value is zero: zero-magnitude terms (R6)
        stim = '{37, 37, 37, 37, 37, 37, 37, 37};
        set_gb(64, 10);
        model();
        send(M);
        collect(1'b0, "R6 zero variance gives beta");
        idle(2);
    endtask

    task automatic test_neg_gamma();
        // gamma magnitude 96 rounds up to 128 (R6), sign flips (R8)
        stim = '{3, -3, 6, 11, -17, 1023, -900, 2};
        set_gb(-96, -3);
        model();
        send(M);
        collect(1'b0, "R8 negative gamma");
        idle(2);
    endtask

    task automatic test_zero_gamma();
        stim = '{5, 900, -700, 12, 13, -1, 0, 44};
        set_gb(0, 123);
        model();
        send(M);
        collect(1'b0, "R8 zero gamma");
        idle(2);
    endtask

    task automatic test_saturate();
        stim = '{2047, -2048, 2047, -2048, 2047, -2048, 2047, -2048};
        set_gb(2047, 2000);
        model();
        chk("R9 model reaches upper bound", expv[0], 2047);
        send(M);
        collect(1'b0, "R9 upper saturation");
        idle(2);
        set_gb(2047, -2000);
        model();
        chk("R9 model reaches lower bound", expv[1], -2048);
        send(M);
        collect(1'b0, "R9 lower saturation");
        idle(2);
    endtask

    task automatic test_drop();
        stim = '{999, -999, 999, 0, 0, 0, 0, 0};
        send(3);
        idle(3);
        chk("R3 no processing after early last", busy, 0);
        chk("R3 no result after early last", out_valid, 0);
        stim = '{-8, 16, -32, 64, 128, -256, 512, 1};
        set_gb(32, 7);
        model();
        send(M);
        collect(1'b0, "R3 batch after discarded partial");
        idle(2);
    endtask

    task automatic test_busy_ignore();
        stim = '{400, 401, -402, 20, -1, 77, -600, 333};
        set_gb(80, -40);
        model();
        send(M);
        collect(1'b1, "R4 results unaffected by offered samples");
        idle(2);
    endtask

    task automatic test_back_to_back();
        stim = '{10, 20, 30, 40, 50, 60, 70, 80};
        set_gb(64, 0);
        model();
        send(M);
        collect(1'b0, "R11 first batch");
        // next batch starts in the cycle the final result is shown
        stim = '{-5, 250, -250, 125, 0, -1, 1, 1500};
        set_gb(48, 1);
        model();
        send(M);
        collect(1'b0, "R11 batch started with previous final result");
        idle(2);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_flat();
        test_neg_gamma();
        test_zero_gamma();
        test_saturate();
        test_drop();
        test_busy_ignore();
        test_back_to_back();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule